// File: doc/BRIEF.md
# Transmit Collision Retry Controller

This block supervises one frame transmission inside an Ethernet MAC. It counts the bytes that leave the transmitter and watches the collision indication. Each collision is classed as normal or late from a byte window that depends on link speed. It then decides whether the frame goes out again, is given up, or is treated as delivered. It also lengthens short frames. When the last data byte leaves before a programmable minimum byte count is reached, the block keeps the attempt open and raises a flag. While the flag is high, the transmitter sends non-data extension symbols until the count reaches the minimum.

The MAC pulses `frame_start` for every new frame. It pulses `byte_stb` for every byte or extension symbol put on the line, and marks the final data byte with `data_last`. A retransmit pulse restarts the byte count and keeps the collision tally. Backoff timing is left to the MAC. Abort and done each close the attempt.

Top module: `tx_coll_retry`

## Requirements
- R1: After reset, `retransmit`, `abort_tx`, `done` and `ext_active` are all 0, and no byte strobe or collision has any effect until `frame_start` is seen.
- R2: `frame_start` clears the collision tally, so every new frame may collide `coll_limit - 1` times before it is aborted.
- R3: In half duplex, a non-late collision that leaves the tally below `coll_limit` gives a one-cycle `retransmit` pulse in the next cycle. The byte count restarts at 0.
- R4: A collision that brings the tally to `coll_limit` or above gives a one-cycle `abort_tx` pulse in the next cycle, and the attempt ends.
- R5: A collision is late when the bytes already sent before its cycle exceed 64 at `speed` 2'b00 (10 Mb/s) or 2'b01 (100 Mb/s), or exceed 512 when `speed[1]` is 1 (1000 Mb/s).
- R6: With `late_retry_en` = 1, a late collision is handled like a normal one: it is added to the tally and gives retransmit, or abort at the limit.
- R7: With `late_retry_en` = 0, a late collision gives a `done` pulse and ends the attempt. No retransmit or abort follows.
- R8: When `full_duplex` = 1, `coll` is ignored whatever the value of `late_retry_en`. The byte count goes on and the frame completes normally.
- R9: If the byte count including the last data byte is below `min_len`, `ext_active` is 1 from the next cycle. `done` pulses in the cycle after the strobe that brings the count to `min_len`, and `ext_active` is 0 in that same cycle.
- R10: The minimum-length extension of R9 applies in full duplex as well.
- R11: Extension symbols count toward the late window. A collision during extension is classed and handled by R3 to R7, and it ends extension.
- R12: A collision in the same cycle as the last data byte takes priority. The only outcome is the collision's outcome, and extension is not entered.
- R13: If the count including the last data byte reaches `min_len`, `done` pulses in the next cycle and `ext_active` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed | input | 2 | 00 = 10 Mb/s, 01 = 100 Mb/s, 1x = 1000 Mb/s |
| full_duplex | input | 1 | 1 = full duplex (collisions ignored) |
| coll_limit | input | LIM_W | Collision count at which the frame is aborted |
| min_len | input | CNT_W | Minimum bytes on the line, extension included |
| late_retry_en | input | 1 | 1 = retransmit on late collision |
| frame_start | input | 1 | Pulse: new frame begins |
| byte_stb | input | 1 | One byte or extension symbol sent this cycle |
| data_last | input | 1 | With byte_stb: this is the last data byte |
| coll | input | 1 | Collision seen this cycle |
| retransmit | output | 1 | Pulse: send the frame again |
| abort_tx | output | 1 | Pulse: collision limit reached, frame dropped |
| done | output | 1 | Pulse: frame treated as transmitted |
| ext_active | output | 1 | Extension symbols are being sent |

## Verification
A collision and the final data byte can arrive in the same cycle. They are the two events that compete for the same attempt, because one asks for retransmission and the other for extension or completion. The bench drives `coll`, `byte_stb` and `data_last` together on a short frame and on a long frame. It expects only the collision outcome, with `ext_active` left low. It repeats the case past the late window with late retry off, where the expected outcome is `done` from R7 rather than from R9 or R13.

// File: rtl/tx_coll_retry.sv
module tx_coll_retry #(
  parameter int CNT_W    = 16,
  parameter int LIM_W    = 5,
  parameter int SLOW_WIN = 64,
  parameter int GIG_WIN  = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       speed,
  input  logic             full_duplex,
  input  logic [LIM_W-1:0] coll_limit,
  input  logic [CNT_W-1:0] min_len,
  input  logic             late_retry_en,
  input  logic             frame_start,
  input  logic             byte_stb,
  input  logic             data_last,
  input  logic             coll,
  output logic             retransmit,
  output logic             abort_tx,
  output logic             done,
  output logic             ext_active
);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_EXT} st_t;

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WIN_SLOW = CNT_W'(SLOW_WIN);
  localparam logic [CNT_W-1:0] WIN_GIG  = CNT_W'(GIG_WIN);

  st_t              state;
  logic [CNT_W-1:0] byte_cnt;
  logic [LIM_W-1:0] coll_cnt;

  wire              busy      = (state != S_IDLE);
  wire [CNT_W-1:0]  win       = speed[1] ? WIN_GIG : WIN_SLOW;
  wire              is_late   = byte_cnt > win;
  wire              coll_hit  = busy && coll && !full_duplex;
  wire [LIM_W:0]    coll_next = {1'b0, coll_cnt} + 1'b1;
  wire              limit_hit = coll_next >= {1'b0, coll_limit};
  wire [CNT_W-1:0]  cnt_inc   = (byte_cnt == CNT_MAX) ? byte_cnt : byte_cnt + 1'b1;
  wire              reach_min = cnt_inc >= min_len;

  assign ext_active = (state == S_EXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      byte_cnt   <= '0;
      coll_cnt   <= '0;
      retransmit <= 1'b0;
      abort_tx   <= 1'b0;
      done       <= 1'b0;
    end else begin
      retransmit <= 1'b0;
      abort_tx   <= 1'b0;
      done       <= 1'b0;
      if (frame_start) begin
        state    <= S_DATA;
        byte_cnt <= '0;
        coll_cnt <= '0;
      end else if (coll_hit) begin
        if (is_late && !late_retry_en) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end else if (limit_hit) begin
          abort_tx <= 1'b1;
          coll_cnt <= coll_next[LIM_W-1:0];
          state    <= S_IDLE;
        end else begin
          retransmit <= 1'b1;
          coll_cnt   <= coll_next[LIM_W-1:0];
          byte_cnt   <= '0;
          state      <= S_DATA;
        end
      end else if (byte_stb && busy) begin
        byte_cnt <= cnt_inc;
        if (state == S_DATA && data_last) begin
          if (reach_min) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_EXT;
          end
        end else if (state == S_EXT && reach_min) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/tx_coll_retry_chk.sv
module tx_coll_retry_chk (
  input logic clk,
  input logic rst_n,
  input logic full_duplex,
  input logic frame_start,
  input logic byte_stb,
  input logic data_last,
  input logic coll,
  input logic retransmit,
  input logic abort_tx,
  input logic done,
  input logic ext_active
);

  p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retransmit, abort_tx, done}));

  p_fd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(full_duplex) |-> (!retransmit && !abort_tx));

  p_abort_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_tx |-> $past(coll));

  p_retx_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    retransmit |-> $past(coll));

  p_ext_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_active) |-> $past(byte_stb && data_last));

  p_ext_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_active) |-> (done || abort_tx || retransmit || $past(frame_start)));

endmodule

bind tx_coll_retry tx_coll_retry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .frame_start(frame_start),
  .byte_stb(byte_stb), .data_last(data_last), .coll(coll),
  .retransmit(retransmit), .abort_tx(abort_tx), .done(done), .ext_active(ext_active)
);

// File: tb/tx_coll_retry_tb.sv
module tx_coll_retry_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] speed = 2'b01;
  logic full_duplex = 1'b0;
  logic [4:0] coll_limit = 5'd16;
  logic [15:0] min_len = 16'd60;
  logic late_retry_en = 1'b0;
  logic frame_start = 1'b0, byte_stb = 1'b0, data_last = 1'b0, coll = 1'b0;
  logic retransmit, abort_tx, done, ext_active;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tx_coll_retry u_dut (
    .clk(clk), .rst_n(rst_n), .speed(speed), .full_duplex(full_duplex),
    .coll_limit(coll_limit), .min_len(min_len), .late_retry_en(late_retry_en),
    .frame_start(frame_start), .byte_stb(byte_stb), .data_last(data_last), .coll(coll),
    .retransmit(retransmit), .abort_tx(abort_tx), .done(done), .ext_active(ext_active)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int outs();
    return {28'd0, retransmit, abort_tx, done, ext_active};
  endfunction

  task automatic step(input logic fs, input logic st, input logic dl, input logic cl);
    frame_start = fs; byte_stb = st; data_last = dl; coll = cl;
    @(negedge clk);
  endtask

  task automatic send(input int n, input logic last);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, last && (i == n - 1), 1'b0);
  endtask

  task automatic t_reset;
    step(0, 1, 1, 1);
    chk("R1 outputs quiet before frame_start", outs(), 0);
    step(0, 0, 0, 0);
  endtask

  task automatic t_long_frame;
    speed = 2'b01; full_duplex = 0; min_len = 60;
    step(1, 0, 0, 0);
    send(64, 1);
    chk("R13 done on last byte (r,a,d,e)", outs(), 4'b0010);
    step(0, 0, 0, 0);
    chk("R13 done is one cycle", outs(), 0);
  endtask

  task automatic t_short(input logic fd, input string tag);
    int ext_ok = 1;
    full_duplex = fd; speed = 2'b01; min_len = 60;
    step(1, 0, 0, 0);
    send(20, 1);
    chk({tag, " extension entered"}, outs(), 4'b0001);
    for (int i = 0; i < 39; i++) begin
      step(0, 1, 0, 0);
      if (outs() != 4'b0001) ext_ok = 0;
    end
    chk({tag, " extension held until min"}, ext_ok, 1);
    step(0, 1, 0, 0);
    chk({tag, " done at min, ext cleared"}, outs(), 4'b0010);
    step(0, 0, 0, 0);
    full_duplex = 0;
  endtask

  task automatic t_limit;
    coll_limit = 3; speed = 2'b01; late_retry_en = 0;
    step(1, 0, 0, 0);
    send(10, 0);
    step(0, 0, 0, 1);
    chk("R3 first collision retransmits", outs(), 4'b1000);
    send(5, 0);
    step(0, 0, 0, 1);
    chk("R3 second collision retransmits", outs(), 4'b1000);
    step(0, 0, 0, 1);
    chk("R4 third collision aborts at limit", outs(), 4'b0100);
    step(0, 0, 0, 1);
    chk("R4 idle after abort ignores collision", outs(), 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 1);
    chk("R2 new frame tally cleared", outs(), 4'b1000);
    step(0, 0, 0, 0);
    coll_limit = 16;
  endtask

  task automatic t_window(input logic [1:0] spd, input int win, input string tag);
    speed = spd; late_retry_en = 0; min_len = 0;
    step(1, 0, 0, 0);
    send(win, 0);
    step(0, 0, 0, 1);
    chk({tag, " at window edge is normal"}, outs(), 4'b1000);
    send(win + 1, 0);
    step(0, 0, 0, 1);
    chk({tag, " past window is late, R7 done"}, outs(), 4'b0010);
    step(0, 0, 0, 0);
    min_len = 60;
  endtask

  task automatic t_late_retry;
    speed = 2'b01; late_retry_en = 1; coll_limit = 2;
    step(1, 0, 0, 0);
    send(70, 0);
    step(0, 0, 0, 1);
    chk("R6 late collision retransmits", outs(), 4'b1000);
    send(70, 0);
    step(0, 0, 0, 1);
    chk("R6 late collision counts to limit", outs(), 4'b0100);
    step(0, 0, 0, 0);
    late_retry_en = 0; coll_limit = 16;
  endtask

  task automatic t_full_duplex;
    int quiet = 1;
    full_duplex = 1; speed = 2'b01; min_len = 60;
    for (int k = 0; k < 2; k++) begin
      late_retry_en = k[0];
      step(1, 0, 0, 0);
      send(10, 0);
      step(0, 0, 0, 1);
      if (outs() != 0) quiet = 0;
      send(100, 0);
      step(0, 0, 0, 1);
      if (outs() != 0) quiet = 0;
      send(1, 1);
      chk("R8 frame completes after ignored collisions", outs(), 4'b0010);
    end
    chk("R8 collisions ignored in full duplex", quiet, 1);
    step(0, 0, 0, 0);
    full_duplex = 0; late_retry_en = 0;
  endtask

  task automatic t_ext_late;
    speed = 2'b10; min_len = 600; late_retry_en = 0;
    step(1, 0, 0, 0);
    send(100, 1);
    send(412, 0);
    step(0, 0, 0, 1);
    chk("R11 collision in extension within window retransmits", outs(), 4'b1000);
    send(100, 1);
    chk("R11 extension re-entered", outs(), 4'b0001);
    send(413, 0);
    step(0, 0, 0, 1);
    chk("R11 late collision in extension gives done", outs(), 4'b0010);
    step(0, 0, 0, 0);
    speed = 2'b01; min_len = 60;
  endtask

  task automatic t_same_cycle;
    speed = 2'b01; min_len = 60; late_retry_en = 0;
    step(1, 0, 0, 0);
    send(19, 0);
    step(0, 1, 1, 1);
    chk("R12 short frame last byte + collision", outs(), 4'b1000);
    send(70, 0);
    step(0, 1, 1, 1);
    chk("R12 late collision on last byte gives done only", outs(), 4'b0010);
    step(0, 0, 0, 0);
    chk("R12 no extension afterwards", outs(), 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs zero in reset", outs(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long_frame();
    t_short(1'b0, "R9");
    t_short(1'b1, "R10");
    t_limit();
    t_window(2'b00, 64, "R5 10M");
    t_window(2'b01, 64, "R5 100M");
    t_window(2'b10, 512, "R5 1G");
    t_late_retry();
    t_full_duplex();
    t_ext_late();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule